// File: doc/BRIEF.md
# Pixel-to-Lane Serializer with Selectable Bit Mapping

This block turns a parallel video stream into the bit streams of a seven-slot serial display link. Each pixel-clock period it accepts one pixel: 8-bit red, green and blue plus horizontal sync, vertical sync and data enable. It spreads those bits over three or four data lanes, seven slots per lane per pixel, and it drives a clock lane that marks the pixel period. The slot rate comes from a clock enable that the surrounding logic supplies. The lane outputs are plain single-ended bits that go to the output buffers.

A two-bit mapping input selects the slot layout. The first option is a 6-bit-per-colour layout on three lanes. The second is a 24-bit layout in which the upper colour bits use the first three lanes. The third is a 24-bit layout in which the first three lanes carry the lower six bits of each colour and the fourth lane carries the two top bits. The block captures the pixel and the mapping together in the last slot of each period. It then shifts them out during the next period, so the latency is one pixel period and a mapping change takes effect only at a pixel boundary.

Top module: `pixel_lane_serializer`

## Requirements
- R1: A pixel period lasts seven slot enables. The slot position advances only on a cycle with `slot_ce` high. On any cycle without it, every output holds its value.
- R2: `lane_clk` is high in slots 0, 1, 5 and 6 and low in slots 2, 3 and 4.
- R3: Control bits go onto lane 2 as follows: slot 0 carries data enable, slot 1 carries vertical sync and slot 2 carries horizontal sync. In both 24-bit layouts, slot 0 of lane 3 is always 0.
- R4: With `map_sel` = 2'b00 (6-bit layout), the block uses the upper six bits of each colour. Call these r, g and b, indexed 5..0. In slot order 0..6, lane 0 sends g0,r5,r4,r3,r2,r1,r0. Lane 1 sends b1,b0,g5,g4,g3,g2,g1. Lane 2 sends DE,VS,HS,b5,b4,b3,b2. Lane 3 stays 0 and `lane3_en` is low.
- R5: `map_sel` = 2'b11 behaves exactly like 2'b00.
- R6: With `map_sel` = 2'b01, lanes 0 to 2 follow the R4 layout using colour bits 7..2. Lane 3 sends 0,B1,B0,G1,G0,R1,R0 in slot order, and `lane3_en` is high.
- R7: With `map_sel` = 2'b10, lanes 0 to 2 follow the R4 layout using colour bits 5..0. Lane 3 sends 0,B7,B6,G7,G6,R7,R6 in slot order, and `lane3_en` is high.
- R8: The pixel and mapping are sampled on the slot enable of slot 6. Their slot 0 appears at the outputs right after that edge, which gives one pixel period of latency.
- R9: Changes to the pixel or to `map_sel` that are withdrawn before the slot 6 enable have no effect. `lane3_en` changes only at a pixel boundary.
- R10: While `rst_n` is low and on the first cycle after it is released, all data lanes are 0, `lane3_en` is 0 and the slot position is 0, so `lane_clk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that carries the slot-rate enable |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_ce | input | 1 | One-cycle enable per bit slot |
| map_sel | input | 2 | Slot layout select (00/11 6-bit, 01 24-bit upper, 10 24-bit lower) |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| lane_dat | output | 4 | Serial data lanes 0..3 |
| lane_clk | output | 1 | Clock lane pattern |
| lane3_en | output | 1 | High when lane 3 carries data |

## Verification
On the slot 6 enable two things happen on the same edge: the last bit of the outgoing pixel leaves, and the next pixel with its mapping is loaded. The bench sends pixels back to back, each with a different layout, and checks every slot of every lane. If the load corrupted slot 6, or if the new mapping leaked into the old pixel, the slot 6 value or `lane3_en` would be wrong. A second test pulses a mapping and colour change in the middle of a period and withdraws it before slot 6, then checks the next period against the original pixel. The remaining tests are thinned-out slot enables and a reset in the middle of a period.

// File: rtl/pxs_pkg.sv
// Package: shared constants and types for the pixel-to-lane serializer.
// Assumes seven slots per pixel and 8-bit colour components.
package pxs_pkg;
    localparam int PXS_SLOTS  = 7;
    localparam int PXS_LANES  = 4;
    localparam int PXS_CW     = 8;
    localparam int PXS_NARROW = 6;
    localparam int PXS_IDX_W  = $clog2(PXS_SLOTS);

    typedef enum logic [1:0] {
        MAP_NARROW   = 2'b00,
        MAP_WIDE_HI  = 2'b01,
        MAP_WIDE_LO  = 2'b10,
        MAP_NARROW_X = 2'b11
    } map_e;

    typedef struct packed {
        logic [PXS_CW-1:0] r;
        logic [PXS_CW-1:0] g;
        logic [PXS_CW-1:0] b;
        logic              hs;
        logic              vs;
        logic              de;
    } pixel_t;

    typedef logic [PXS_LANES-1:0][PXS_SLOTS-1:0] lane_words_t;
endpackage

// File: rtl/pxs_slot_counter.sv
// Slot counter: tracks the current slot within a pixel period.
// Assumes slot_ce marks every slot. The count wraps from SLOTS-1 to 0.
module pxs_slot_counter #(
    parameter int SLOTS = 7,
    localparam int IW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_ce,
    output logic [IW-1:0] slot_idx,
    output logic          last_slot
);
    localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

    assign last_slot = (slot_idx == LAST);

    // Advance the slot position on each enable, wrapping at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_idx <= '0;
        end else if (slot_ce) begin
            slot_idx <= last_slot ? '0 : slot_idx + IW'(1);
        end
    end
endmodule

// File: rtl/pxs_lane_mapper.sv
// Lane mapper: arranges one pixel into per-lane slot words (bit k = slot k).
// Purely combinational. Assumes the package's seven-slot, 8-bit layout.
module pxs_lane_mapper
    import pxs_pkg::*;
(
    input  pixel_t      pix,
    input  logic [1:0]  mode,
    output lane_words_t words,
    output logic        wide
);
    localparam logic CTL3_LEVEL = 1'b0;

    map_e              mode_e;
    logic [PXS_NARROW-1:0] r6, g6, b6;

    assign mode_e = map_e'(mode);

    // Choose the six colour bits that lanes 0..2 carry for the mode.
    always_comb begin
        if (mode_e == MAP_WIDE_LO) begin
            r6 = pix.r[PXS_NARROW-1:0];
            g6 = pix.g[PXS_NARROW-1:0];
            b6 = pix.b[PXS_NARROW-1:0];
        end else begin
            r6 = pix.r[PXS_CW-1:PXS_CW-PXS_NARROW];
            g6 = pix.g[PXS_CW-1:PXS_CW-PXS_NARROW];
            b6 = pix.b[PXS_CW-1:PXS_CW-PXS_NARROW];
        end
    end

    // Place colour and control bits into slot positions, one word per lane.
    always_comb begin
        words[0] = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
        words[1] = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
        words[2] = {b6[2], b6[3], b6[4], b6[5], pix.hs, pix.vs, pix.de};
        unique case (mode_e)
            MAP_WIDE_HI: words[3] = {pix.r[0], pix.r[1], pix.g[0], pix.g[1],
                                     pix.b[0], pix.b[1], CTL3_LEVEL};
            MAP_WIDE_LO: words[3] = {pix.r[6], pix.r[7], pix.g[6], pix.g[7],
                                     pix.b[6], pix.b[7], CTL3_LEVEL};
            default:     words[3] = '0;
        endcase
    end

    // Flag the modes that drive the fourth lane.
    assign wide = (mode_e == MAP_WIDE_HI) || (mode_e == MAP_WIDE_LO);
endmodule

// File: rtl/pxs_lane_shifter.sv
// Lane shifter: holds one lane word and presents it LSB first, one slot per shift.
// Assumes load and shift never coincide. Reset clears the lane to 0.
module pxs_lane_shifter #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [SLOTS-1:0] word,
    output logic             bit_o
);
    logic [SLOTS-1:0] sh_q;

    // Load a fresh word at the boundary, otherwise move to the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= word;
        end else if (shift) begin
            sh_q <= {1'b0, sh_q[SLOTS-1:1]};
        end
    end

    assign bit_o = sh_q[0];
endmodule

// File: rtl/pixel_lane_serializer.sv
// Top: serializes one pixel per period onto four data lanes and a clock lane.
// It captures the pixel and mapping on the slot 6 enable and sends them in the
// next period. Assumes slot_ce comes from a slot-rate source in the clk domain.
module pixel_lane_serializer
    import pxs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_ce,
    input  logic [1:0]           map_sel,
    input  logic [PXS_CW-1:0]    pix_r,
    input  logic [PXS_CW-1:0]    pix_g,
    input  logic [PXS_CW-1:0]    pix_b,
    input  logic                 pix_hs,
    input  logic                 pix_vs,
    input  logic                 pix_de,
    output logic [PXS_LANES-1:0] lane_dat,
    output logic                 lane_clk,
    output logic                 lane3_en
);
    localparam logic [PXS_IDX_W-1:0] CLK_LOW_FIRST = PXS_IDX_W'(2);
    localparam logic [PXS_IDX_W-1:0] CLK_LOW_LAST  = PXS_IDX_W'(PXS_SLOTS - 3);

    logic [PXS_IDX_W-1:0] slot_idx;
    logic                 last_slot;
    logic                 load_en;
    logic                 shift_en;
    pixel_t               pix_in;
    lane_words_t          words;
    logic                 wide;

    pxs_slot_counter #(.SLOTS(PXS_SLOTS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_ce  (slot_ce),
        .slot_idx (slot_idx),
        .last_slot(last_slot)
    );

    assign pix_in   = '{r: pix_r, g: pix_g, b: pix_b, hs: pix_hs, vs: pix_vs, de: pix_de};
    assign load_en  = slot_ce && last_slot;
    assign shift_en = slot_ce && !last_slot;

    pxs_lane_mapper u_map (
        .pix  (pix_in),
        .mode (map_sel),
        .words(words),
        .wide (wide)
    );

    for (genvar ln = 0; ln < PXS_LANES; ln++) begin : g_lane
        pxs_lane_shifter #(.SLOTS(PXS_SLOTS)) u_sh (
            .clk  (clk),
            .rst_n(rst_n),
            .load (load_en),
            .shift(shift_en),
            .word (words[ln]),
            .bit_o(lane_dat[ln])
        );
    end

    // Latch the fourth-lane enable with the pixel at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane3_en <= 1'b0;
        end else if (load_en) begin
            lane3_en <= wide;
        end
    end

    // Clock lane: low for the middle three slots, high elsewhere.
    assign lane_clk = !((slot_idx >= CLK_LOW_FIRST) && (slot_idx <= CLK_LOW_LAST));
endmodule

// File: rtl/pxs_checker.sv
// Checker: temporal properties of the serializer, bound to the top module.
module pxs_checker #(
    parameter int SLOTS = 7,
    localparam int IW   = $clog2(SLOTS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slot_ce,
    input logic [IW-1:0] slot_idx,
    input logic [3:0]    lane_dat,
    input logic          lane_clk,
    input logic          lane3_en
);
    localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

    // R1
    hold_without_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_ce |=> ($stable(lane_dat) && $stable(lane_clk) && $stable(lane3_en)));

    // R1
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx <= LAST);

    // R8
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_ce && slot_idx == LAST) |=> (slot_idx == '0));

    // R2
    clk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lane_clk) |-> (slot_idx == IW'(2)));

    // R4
    idle_lane3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lane3_en |-> !lane_dat[3]);

    // R9
    mode_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lane3_en) |-> ($past(slot_ce) && $past(slot_idx) == LAST));

    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lane_dat == 4'b0 && slot_idx == '0 && !lane3_en));
endmodule

bind pixel_lane_serializer pxs_checker #(.SLOTS(pxs_pkg::PXS_SLOTS)) u_pxs_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_ce (slot_ce),
    .slot_idx(slot_idx),
    .lane_dat(lane_dat),
    .lane_clk(lane_clk),
    .lane3_en(lane3_en)
);

// File: tb/tb_pixel_lane_serializer.sv
`timescale 1ns/1ps
module tb_pixel_lane_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_ce = 1'b1;
    logic [1:0] map_sel = 2'b00;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic       pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
    logic [3:0] lane_dat;
    logic       lane_clk, lane3_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pixel_lane_serializer dut (
        .clk(clk), .rst_n(rst_n), .slot_ce(slot_ce), .map_sel(map_sel),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
        .lane_dat(lane_dat), .lane_clk(lane_clk), .lane3_en(lane3_en)
    );

    // vector: {mode[1:0], r[7:0], g[7:0], b[7:0], hs, vs, de}
    localparam int NV = 8;
    localparam logic [28:0] VEC [NV] = '{
        {2'b00, 8'hA5, 8'h3C, 8'hF0, 1'b1, 1'b0, 1'b1},
        {2'b01, 8'h5A, 8'hC3, 8'h0F, 1'b0, 1'b1, 1'b0},
        {2'b10, 8'h81, 8'h7E, 8'hC6, 1'b1, 1'b1, 1'b1},
        {2'b11, 8'hFF, 8'h00, 8'hAA, 1'b0, 1'b0, 1'b1},
        {2'b01, 8'h12, 8'h34, 8'h56, 1'b1, 1'b0, 1'b0},
        {2'b10, 8'hFE, 8'h01, 8'h7F, 1'b0, 1'b1, 1'b1},
        {2'b00, 8'h00, 8'hFF, 8'h33, 1'b1, 1'b1, 1'b0},
        {2'b10, 8'h69, 8'h96, 8'hE1, 1'b0, 1'b0, 1'b0}
    };
    localparam logic [28:0] ZERO_VEC = '0;

    // Expected slot bit of one lane, from the layouts in R3, R4, R6, R7.
    function automatic logic exp_bit(input logic [28:0] v, input int lane, input int s);
        logic [1:0] md = v[28:27];
        logic [7:0] r = v[26:19], g = v[18:11], b = v[10:3];
        logic [5:0] r6, g6, b6;
        if (md == 2'b10) begin
            r6 = r[5:0]; g6 = g[5:0]; b6 = b[5:0];
        end else begin
            r6 = r[7:2]; g6 = g[7:2]; b6 = b[7:2];
        end
        case (lane)
            0: return (s == 0) ? g6[0] : r6[6-s];
            1: return (s == 0) ? b6[1] : (s == 1) ? b6[0] : g6[7-s];
            2: return (s == 0) ? v[0] : (s == 1) ? v[1] : (s == 2) ? v[2] : b6[8-s];
            default: begin
                if (md == 2'b01) begin
                    case (s)
                        1: return b[1]; 2: return b[0]; 3: return g[1];
                        4: return g[0]; 5: return r[1]; 6: return r[0];
                        default: return 1'b0;
                    endcase
                end else if (md == 2'b10) begin
                    case (s)
                        1: return b[7]; 2: return b[6]; 3: return g[7];
                        4: return g[6]; 5: return r[7]; 6: return r[6];
                        default: return 1'b0;
                    endcase
                end
                return 1'b0;
            end
        endcase
    endfunction

    function automatic string mode_tag(input logic [28:0] v);
        case (v[28:27])
            2'b00: return "R4";
            2'b01: return "R6";
            2'b10: return "R7";
            default: return "R5";
        endcase
    endfunction

    task automatic drive(input logic [28:0] v);
        map_sel = v[28:27]; pix_r = v[26:19]; pix_g = v[18:11]; pix_b = v[10:3];
        pix_hs = v[2]; pix_vs = v[1]; pix_de = v[0];
    endtask

    // One check: {lane_clk, lane3_en, lanes 3..0} at slot s of pixel v (R2, R3).
    task automatic check_slot(input logic [28:0] v, input int s, input string tag);
        logic [5:0] exp, act;
        exp[5] = (s < 2) || (s > 4);
        exp[4] = (v[28:27] == 2'b01) || (v[28:27] == 2'b10);
        for (int ln = 0; ln < 4; ln++) exp[ln] = exp_bit(v, ln, s);
        act = {lane_clk, lane3_en, lane_dat};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s slot %0d: actual=%b expected=%b", tag, s, act, exp);
        end
    endtask

    // One pixel period: drive nxt, check each slot of cur; gap thins slot_ce (R1).
    task automatic period(input logic [28:0] nxt, input logic [28:0] cur,
                          input string tag, input bit gap);
        drive(nxt);
        for (int s = 0; s < 7; s++) begin
            check_slot(cur, s, tag);
            if (gap) begin
                slot_ce = 1'b0;
                @(negedge clk);
                check_slot(cur, s, "R1 hold");
                slot_ce = 1'b1;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        logic [28:0] pv, qv, sv;
        pv = {2'b10, 8'hC9, 8'h5B, 8'h2D, 1'b0, 1'b1, 1'b1};
        qv = {2'b01, 8'h3E, 8'hD4, 8'h87, 1'b1, 1'b0, 1'b1};
        sv = {2'b01, 8'hF0, 8'h0F, 8'hCC, 1'b1, 1'b1, 1'b1};

        // R10: reset state
        repeat (3) @(negedge clk);
        check_slot(ZERO_VEC, 0, "R10 reset");
        rst_n = 1'b1;

        // Table walk: pixel i is driven while pixel i-1 is checked (R8 latency).
        for (int i = 0; i <= NV; i++) begin
            if (i == 0) period(VEC[0], ZERO_VEC, "R10 post-reset", 1'b0);
            else        period((i < NV) ? VEC[i] : ZERO_VEC, VEC[i-1], mode_tag(VEC[i-1]), 1'b0);
        end

        // R9: mid-period glitch on mapping and colour, withdrawn before slot 6.
        drive(pv);
        for (int s = 0; s < 7; s++) begin
            if (s == 3) begin map_sel = 2'b01; pix_r = 8'h00; pix_de = 1'b0; end
            if (s == 5) drive(pv);
            check_slot(ZERO_VEC, s, "R9 no early effect");
            @(negedge clk);
        end
        // R9 outcome checked while R1 thinned enables load qv.
        period(qv, pv, "R9", 1'b1);
        period(ZERO_VEC, qv, "R1", 1'b0);

        // R10: reset in mid-period.
        drive(sv);
        for (int s = 0; s < 3; s++) begin
            check_slot(ZERO_VEC, s, "R10 pre");
            @(negedge clk);
        end
        rst_n = 1'b0;
        @(negedge clk);
        check_slot(ZERO_VEC, 0, "R10 mid reset");
        rst_n = 1'b1;
        period(sv, ZERO_VEC, "R10 cleared", 1'b0);
        period(ZERO_VEC, sv, "R8", 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule